// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts what a processor core does. One cycle counter and a set of event counters sit behind a small register port. The number of event counters is set by a parameter. Each event counter is given an event number. It then counts the clock cycles in which the matching line of the event input bus is high. Event number 0 instead counts software increments, which come through a register.

Software starts the unit with a global enable bit and picks counters through enable masks. Each mask has a set address and a clear address. Software can slow the cycle counter to one step per 64 clocks. When a counter wraps, an overflow flag is raised, and that flag can drive an interrupt. Event counters are reached indirectly: a select register names one counter, and two data addresses then access that counter's event type and its count. The register port is a plain single-cycle access. Writes take effect at the clock edge. Read data follows the address combinationally in the same cycle. The port has no back-pressure, so every access is accepted in the cycle it is presented.

Top module: `perf_counter_unit`

## Requirements
- R1: While control bit 0 (address 0x0) is clear, no counter changes, except through a direct write or a reset bit.
- R2: Writing 1 to control bit 1 zeroes every event counter, and writing 1 to control bit 2 zeroes the cycle counter (address 0x6). Both bits read back as 0. A reset takes priority over a count or a load in the same cycle.
- R3: With control bit 3 set, the cycle counter advances on every 64th enabled clock. Setting control bit 2 also restarts the 64-clock interval. With control bit 3 clear, the cycle counter advances on every enabled clock.
- R4: An enabled event counter whose type is k, for 1 <= k < NUM_EVT_LINES, increments in each enabled cycle in which event line k is high. It ignores all other lines, and a type at or above NUM_EVT_LINES never counts.
- R5: The count-enable mask is set by writing ones to 0x1 and cleared by writing ones to 0x2. Reading either address returns the mask. Bit 31 is the cycle counter, bits 0..N-1 are the event counters, and all other bits read 0.
- R6: A counter with type 0 increments only when a 1 is written to its bit of the software-increment address 0x4, with the unit and the counter enabled.
- R7: The interrupt-enable mask has the same layout, with set at 0xA and clear at 0xB. The output `irq` is high while any overflow bit is set together with its interrupt-enable bit.
- R8: When a counter steps from all-ones to zero, its bit in the overflow register (0x3, same layout) is set. Writing 1 to a bit of that register clears it, and a wrap in the same cycle wins over the clear.
- R9: The select register (0x5) chooses which event counter the type address (0x7) and the count address (0x8) access. When the select value is at or above N, those two addresses read 0 and ignore writes.
- R10: An access with `acc_user` high is accepted only while bit 0 of the user-access register (0x9) is set. Otherwise it reads 0 and its write has no effect. The user-access register accepts privileged writes only.
- R11: Control bits 15:11 read the number of event counters, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_user | input | 1 | Access comes from unprivileged code |
| acc_addr | input | 4 | Register address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the same cycle as the access |
| events | input | NUM_EVT_LINES | Event pulse lines; line k feeds type k |
| irq | output | 1 | Overflow interrupt |

## Verification
The overflow register can be set by a counter wrap and cleared by a software write-one-to-clear in the same clock. The bench provokes this by loading an event counter with all-ones and then, in one cycle, driving its event line high and writing that counter's bit to the overflow address. The flag must read back as set, and the counter must read zero. A count-register load and a control reset bit can likewise land on a cycle in which the counter would step. The reset-bit tests check the priority of the reset in that case.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam logic [3:0] A_CTRL     = 4'h0;
  localparam logic [3:0] A_CEN_SET  = 4'h1;
  localparam logic [3:0] A_CEN_CLR  = 4'h2;
  localparam logic [3:0] A_OVF      = 4'h3;
  localparam logic [3:0] A_SWINC    = 4'h4;
  localparam logic [3:0] A_SEL      = 4'h5;
  localparam logic [3:0] A_CYCLE    = 4'h6;
  localparam logic [3:0] A_EVTYPE   = 4'h7;
  localparam logic [3:0] A_EVCOUNT  = 4'h8;
  localparam logic [3:0] A_USER     = 4'h9;
  localparam logic [3:0] A_IEN_SET  = 4'hA;
  localparam logic [3:0] A_IEN_CLR  = 4'hB;

  localparam int CTL_EN    = 0;
  localparam int CTL_EVRST = 1;
  localparam int CTL_CYRST = 2;
  localparam int CTL_DIV   = 3;
  localparam int CYC_BIT   = 31;
endpackage

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div_en,
  input  logic restart,
  output logic tick
);
  localparam int W = $clog2(DIV);
  logic [W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (run)     phase <= (phase == W'(DIV - 1)) ? '0 : phase + 1'b1;
  end

  assign tick = run && (!div_en || phase == W'(DIV - 1));

  AST_DIV_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en && $past(div_en) && tick) |-> !$past(tick)); // R3
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (load)  count <= load_val;
    else if (inc)   count <= count + 1'b1;
  end

  assign wrap = inc && !clear && !load && (&count);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load && !inc) |=> $stable(count)); // R1
endmodule

// File: rtl/pmu_event_slot.sv
module pmu_event_slot #(
  parameter int W      = 32,
  parameter int TYPE_W = 8,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  events,
  input  logic              swinc,
  input  logic              run,
  input  logic              clear,
  input  logic              type_we,
  input  logic [TYPE_W-1:0] type_wdata,
  input  logic              cnt_we,
  input  logic [W-1:0]      cnt_wdata,
  output logic [TYPE_W-1:0] ev_type,
  output logic [W-1:0]      count,
  output logic              wrap
);
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;
  logic hit;

  always_ff @(posedge clk) begin
    if (!rst_n)       ev_type <= '0;
    else if (type_we) ev_type <= type_wdata;
  end

  always_comb begin
    if (ev_type == '0)                   hit = swinc;
    else if (ev_type < TYPE_W'(LINES))   hit = events[ev_type[LW-1:0]];
    else                                 hit = 1'b0;
  end

  pmu_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(cnt_we),
    .load_val(cnt_wdata), .inc(run && hit), .count(count), .wrap(wrap)
  );

  AST_SOFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_type == '0 && !swinc && !clear && !cnt_we) |=> $stable(count)); // R6
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CNT       = 4,
  parameter int NUM_EVT_LINES = 16,
  parameter int TYPE_W        = 8,
  parameter int PRESCALE      = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_en,
  input  logic                     acc_we,
  input  logic                     acc_user,
  input  logic [3:0]               acc_addr,
  input  logic [31:0]              acc_wdata,
  output logic [31:0]              acc_rdata,
  input  logic [NUM_EVT_LINES-1:0] events,
  output logic                     irq
);
  localparam int DW    = 32;
  localparam int SEL_W = 8;
  localparam int IW    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  logic               ctl_en, ctl_div, user_en;
  logic [NUM_CNT-1:0] cen_evt, ien_evt, ovf_evt;
  logic               cen_cyc, ien_cyc, ovf_cyc;
  logic [SEL_W-1:0]   sel;

  logic acc_ok, wr;
  logic ev_clear, cy_clear, sel_ok;
  logic [NUM_CNT-1:0] swinc_v, wrap_evt;
  logic [DW-1:0]      ev_cnt [NUM_CNT];
  logic [TYPE_W-1:0]  ev_typ [NUM_CNT];
  logic [DW-1:0]      cyc_cnt;
  logic               cyc_tick, cyc_wrap;

  assign acc_ok   = acc_en && (!acc_user || user_en);
  assign wr       = acc_ok && acc_we;
  assign ev_clear = wr && acc_addr == A_CTRL && acc_wdata[CTL_EVRST];
  assign cy_clear = wr && acc_addr == A_CTRL && acc_wdata[CTL_CYRST];
  assign sel_ok   = sel < SEL_W'(NUM_CNT);
  assign swinc_v  = (wr && acc_addr == A_SWINC) ? acc_wdata[NUM_CNT-1:0] : '0;

  // Configuration and status registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en  <= 1'b0; ctl_div <= 1'b0; user_en <= 1'b0;
      cen_evt <= '0;   cen_cyc <= 1'b0;
      ien_evt <= '0;   ien_cyc <= 1'b0;
      ovf_evt <= '0;   ovf_cyc <= 1'b0;
      sel     <= '0;
    end else begin
      if (wr) begin
        unique case (acc_addr)
          A_CTRL: begin
            ctl_en  <= acc_wdata[CTL_EN];
            ctl_div <= acc_wdata[CTL_DIV];
          end
          A_CEN_SET: begin
            cen_evt <= cen_evt | acc_wdata[NUM_CNT-1:0];
            cen_cyc <= cen_cyc | acc_wdata[CYC_BIT];
          end
          A_CEN_CLR: begin
            cen_evt <= cen_evt & ~acc_wdata[NUM_CNT-1:0];
            cen_cyc <= cen_cyc & ~acc_wdata[CYC_BIT];
          end
          A_IEN_SET: begin
            ien_evt <= ien_evt | acc_wdata[NUM_CNT-1:0];
            ien_cyc <= ien_cyc | acc_wdata[CYC_BIT];
          end
          A_IEN_CLR: begin
            ien_evt <= ien_evt & ~acc_wdata[NUM_CNT-1:0];
            ien_cyc <= ien_cyc & ~acc_wdata[CYC_BIT];
          end
          A_SEL:  sel <= acc_wdata[SEL_W-1:0];
          A_USER: if (!acc_user) user_en <= acc_wdata[0];
          default: ;
        endcase
      end
      // overflow: wrap sets, write-one clears, set wins
      if (wr && acc_addr == A_OVF) begin
        ovf_evt <= (ovf_evt & ~acc_wdata[NUM_CNT-1:0]) | wrap_evt;
        ovf_cyc <= (ovf_cyc & ~acc_wdata[CYC_BIT]) | cyc_wrap;
      end else begin
        ovf_evt <= ovf_evt | wrap_evt;
        ovf_cyc <= ovf_cyc | cyc_wrap;
      end
    end
  end

  // Cycle counter path
  pmu_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctl_en && cen_cyc), .div_en(ctl_div),
    .restart(cy_clear), .tick(cyc_tick)
  );

  pmu_counter #(.W(DW)) u_cycle (
    .clk(clk), .rst_n(rst_n), .clear(cy_clear),
    .load(wr && acc_addr == A_CYCLE), .load_val(acc_wdata),
    .inc(cyc_tick), .count(cyc_cnt), .wrap(cyc_wrap)
  );

  // Event counter slots
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
    logic hit_sel;
    assign hit_sel = wr && sel_ok && sel[IW-1:0] == IW'(i);

    pmu_event_slot #(.W(DW), .TYPE_W(TYPE_W), .LINES(NUM_EVT_LINES)) u_slot (
      .clk(clk), .rst_n(rst_n), .events(events), .swinc(swinc_v[i]),
      .run(ctl_en && cen_evt[i]), .clear(ev_clear),
      .type_we(hit_sel && acc_addr == A_EVTYPE), .type_wdata(acc_wdata[TYPE_W-1:0]),
      .cnt_we(hit_sel && acc_addr == A_EVCOUNT), .cnt_wdata(acc_wdata),
      .ev_type(ev_typ[i]), .count(ev_cnt[i]), .wrap(wrap_evt[i])
    );

    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt[i] |=> ovf_evt[i]); // R8
  end

  // Read path
  function automatic logic [DW-1:0] mask32(logic [NUM_CNT-1:0] ev, logic cy);
    logic [DW-1:0] m;
    m = '0;
    m[NUM_CNT-1:0] = ev;
    m[CYC_BIT] = cy;
    return m;
  endfunction

  always_comb begin
    acc_rdata = '0;
    if (acc_ok && !acc_we) begin
      unique case (acc_addr)
        A_CTRL: begin
          acc_rdata[15:11]   = 5'(NUM_CNT);
          acc_rdata[CTL_DIV] = ctl_div;
          acc_rdata[CTL_EN]  = ctl_en;
        end
        A_CEN_SET, A_CEN_CLR: acc_rdata = mask32(cen_evt, cen_cyc);
        A_IEN_SET, A_IEN_CLR: acc_rdata = mask32(ien_evt, ien_cyc);
        A_OVF:     acc_rdata = mask32(ovf_evt, ovf_cyc);
        A_SEL:     acc_rdata = DW'(sel);
        A_CYCLE:   acc_rdata = cyc_cnt;
        A_EVTYPE:  if (sel_ok) acc_rdata = DW'(ev_typ[sel[IW-1:0]]);
        A_EVCOUNT: if (sel_ok) acc_rdata = ev_cnt[sel[IW-1:0]];
        A_USER:    acc_rdata = DW'(user_en);
        default:   acc_rdata = '0;
      endcase
    end
  end

  assign irq = (|(ovf_evt & ien_evt)) || (ovf_cyc && ien_cyc);

  logic any_ev_nonzero;
  always_comb begin
    any_ev_nonzero = 1'b0;
    for (int k = 0; k < NUM_CNT; k++) any_ev_nonzero |= (ev_cnt[k] != '0);
  end

  AST_EVENT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> !any_ev_nonzero); // R2
  AST_CYCLE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cy_clear |=> cyc_cnt == '0); // R2
  AST_CYC_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wrap |=> ovf_cyc); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_evt != '0 || ovf_cyc)); // R7
  AST_USER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_user && !user_en) |-> acc_rdata == '0); // R10
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && acc_addr == A_EVCOUNT && !sel_ok) |-> acc_rdata == '0); // R9
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !(wr && acc_addr == A_CYCLE) && !cy_clear) |=> $stable(cyc_cnt)); // R1
endmodule

// File: tb/perf_counter_unit_test.sv
module perf_counter_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCNT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_we = 1'b0, acc_user = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [15:0] events = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_counter_unit #(.NUM_CNT(NCNT), .NUM_EVT_LINES(16)) uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_user(acc_user), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .events(events), .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] exp_v;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{4'h1, 32'hFFFF_FFFF, 4'h2, 32'h8000_000F, 8'd5},  // R5 set, read clear address
    '{4'h2, 32'h0000_0009, 4'h1, 32'h8000_0006, 8'd5},  // R5 clear
    '{4'hA, 32'h8000_0003, 4'hB, 32'h8000_0003, 8'd7},  // R7 set
    '{4'hB, 32'h8000_0000, 4'hA, 32'h0000_0003, 8'd7},  // R7 clear
    '{4'h5, 32'h0000_0002, 4'h5, 32'h0000_0002, 8'd9},  // R9 select
    '{4'h7, 32'h0000_0005, 4'h7, 32'h0000_0005, 8'd9},  // R9 type
    '{4'h8, 32'h0000_1234, 4'h8, 32'h0000_1234, 8'd9},  // R9 count
    '{4'h5, 32'h0000_0007, 4'h8, 32'h0000_0000, 8'd9},  // R9 out of range read
    '{4'h7, 32'h0000_0009, 4'h7, 32'h0000_0000, 8'd9},  // R9 out of range write
    '{4'h5, 32'h0000_0002, 4'h7, 32'h0000_0005, 8'd9},  // R9 value kept
    '{4'h0, 32'h0000_F800, 4'h0, 32'h0000_2000, 8'd11}  // R11 read-only field
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp_v);
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp_v);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic usr = 1'b0);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_user = usr; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0; acc_user = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, input logic usr = 1'b0);
    acc_en = 1'b1; acc_we = 1'b0; acc_user = usr; acc_addr = a;
    #1 d = acc_rdata;
    acc_en = 1'b0; acc_user = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd(4'h0, v); check("R11 reset ctrl", v, 32'h0000_2000);
    rd(4'h6, v); check("R1 reset cycle", v, 32'h0);
    rd(4'h3, v); check("R8 reset ovf", v, 32'h0);
    check("R7 reset irq", {31'b0, irq}, 32'h0);

    // Register table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      rd(VEC[i].ra, v);
      check($sformatf("R%0d table %0d", VEC[i].req, i), v, VEC[i].exp_v);
    end
    wr(4'h2, 32'hFFFF_FFFF);

    // R1: global enable gates the cycle counter
    wr(4'h1, 32'h8000_0000);
    repeat (10) @(negedge clk);
    rd(4'h6, v); check("R1 disabled hold", v, 32'h0);
    wr(4'h0, 32'h1);
    repeat (10) @(negedge clk);
    rd(4'h6, v); check("R1 enabled count", v, 32'd10);

    // R3 and R2: divide by 64 with cycle reset
    wr(4'h0, 32'hD);
    repeat (63) @(negedge clk);
    rd(4'h6, v); check("R2 R3 before 64th", v, 32'd0);
    @(negedge clk);
    rd(4'h6, v); check("R3 at 64th", v, 32'd1);
    wr(4'h0, 32'h0);

    // R4 and R5: event line counting, disabled counter holds
    wr(4'h5, 32'h1); wr(4'h7, 32'h3); wr(4'h8, 32'h0);
    wr(4'h5, 32'h2); wr(4'h7, 32'h3);
    wr(4'h1, 32'h2);
    wr(4'h0, 32'h1);
    events = 16'h0018;
    repeat (5) @(negedge clk);
    events = '0;
    wr(4'h5, 32'h1);
    rd(4'h8, v); check("R4 event count", v, 32'd5);
    wr(4'h5, 32'h2);
    rd(4'h8, v); check("R5 disabled counter", v, 32'h1234);

    // R6: software increment
    wr(4'h5, 32'h0); wr(4'h8, 32'h0);
    wr(4'h1, 32'h1);
    wr(4'h4, 32'h1); wr(4'h4, 32'h1); wr(4'h4, 32'h1);
    wr(4'h4, 32'h2);
    rd(4'h8, v); check("R6 softinc count", v, 32'd3);
    wr(4'h5, 32'h1);
    rd(4'h8, v); check("R6 non-soft ignores", v, 32'd5);

    // R2: event reset bit, self-clearing
    wr(4'h0, 32'h3);
    rd(4'h8, v); check("R2 event reset", v, 32'd0);
    rd(4'h0, v); check("R2 bits read zero", v, 32'h0000_2001);

    // R8 and R7: wrap, overflow, interrupt, clear
    wr(4'h8, 32'hFFFF_FFFE);
    events = 16'h0008;
    repeat (2) @(negedge clk);
    events = '0;
    rd(4'h8, v); check("R8 wrapped value", v, 32'd0);
    rd(4'h3, v); check("R8 overflow set", v, 32'h2);
    check("R7 irq raised", {31'b0, irq}, 32'h1);
    wr(4'h3, 32'h2);
    rd(4'h3, v); check("R8 w1c", v, 32'h0);
    check("R7 irq dropped", {31'b0, irq}, 32'h0);

    // R8: wrap and clear in the same cycle, set wins
    wr(4'h8, 32'hFFFF_FFFF);
    @(negedge clk);
    events = 16'h0008;
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = 4'h3; acc_wdata = 32'h2;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0; events = '0;
    rd(4'h3, v); check("R8 set beats clear", v, 32'h2);
    rd(4'h8, v); check("R8 count after wrap", v, 32'h0);

    // R8: cycle counter wrap at bit 31
    wr(4'h3, 32'hFFFF_FFFF);
    wr(4'h6, 32'hFFFF_FFFD);
    repeat (3) @(negedge clk);
    rd(4'h3, v); check("R8 cycle wrap bit31", v, 32'h8000_0000);

    // R10: user access gating
    rd(4'h0, v, 1'b1); check("R10 user read blocked", v, 32'h0);
    wr(4'h1, 32'h8, 1'b1);
    rd(4'h1, v); check("R10 user write ignored", v, 32'h8000_0003);
    wr(4'h9, 32'h1);
    rd(4'h0, v, 1'b1); check("R10 user read allowed", v, 32'h0000_2001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule